// File: doc/BRIEF.md
# SPI Master Register Front-End

This block sits between a minimal Wishbone slave port and a word-level serial engine. Software writes words to send through a one-bit address map, and they queue in a transmit FIFO. The serial engine returns one received word for each word it sends, and those words queue in a receive FIFO for software to read. A control register holds an encoded slave index. The block decodes that index onto active-low select lines, which are asserted only while a transfer is in progress.

Two interrupt outputs go to the host. The first reports received data. One build-time mode raises it after every word. The other raises it once, when the last queued word completes and the slave is released. The second output reports that data was lost, either a bus write into a full transmit FIFO or a received word arriving at a full receive FIFO. Separate sticky flags in the status word record the cause.

The engine side uses two interfaces. Words leave on a valid/ready pair. The block keeps valid and data steady until ready is seen, and it offers no further word until the engine returns the result of the current one. Results come back on a valid-only strobe with no back-pressure: a result that arrives at a full receive FIFO is dropped and flagged.

Top module: `spi_master_regs`

## Requirements
- R1: Each bus strobe gets exactly one acknowledge. The acknowledge is high for one clock, in the cycle after the strobe is first seen, and the access takes effect in that same cycle.
- R2: A write to address 0 queues a word for transmission. A read from address 0 returns the oldest received word and removes it, in arrival order. A read from address 0 while the receive FIFO is empty returns zero.
- R3: A write to address 1 stores the slave index in its low SEL_W bits. Select line k (active low) is driven low only while the block is busy and the stored index equals k. All lines are high when the block is idle.
- R4: A read from address 1 returns the status word with these bits: bit0 busy (transmit FIFO not empty or a word in flight), bit1 transmit FIFO not full, bit2 receive FIFO not empty, bit3 receive overflow, bit4 transmit overflow. Every higher bit reads as zero.
- R5: A data write while the transmit FIFO is full is discarded. It sets the sticky transmit-overflow bit and raises the overflow interrupt.
- R6: A received word arriving while the receive FIFO is full is discarded. It sets the sticky receive-overflow bit and raises the overflow interrupt.
- R7: A status read returns the overflow bits as they stood, then clears them both. The overflow interrupt drops in the next cycle unless a new overflow occurs.
- R8: With PER_WORD=0, the data-ready interrupt rises only when a word completes while no further word is queued, that is, when the transaction ends.
- R9: With PER_WORD=1, the data-ready interrupt rises on every completed word, even while more words are still queued.
- R10: The data-ready interrupt is a level. It falls when a read removes the last word from the receive FIFO.
- R11: Toward the engine, valid and data stay stable until ready is sampled high. After a handshake, valid stays low until the result strobe for that word returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr | input | 1 | Register address: 0 data, 1 control/status |
| wb_wdat | input | DW | Write data |
| wb_rdat | output | DW | Read data, valid with acknowledge |
| wb_we | input | 1 | Write enable |
| wb_stb | input | 1 | Strobe |
| wb_ack | output | 1 | One-clock acknowledge |
| eng_tx_valid | output | 1 | Word offered to the serial engine |
| eng_tx_ready | input | 1 | Engine accepts the offered word |
| eng_tx_data | output | DW | Word to shift out |
| eng_rx_valid | input | 1 | Received word strobe, no back-pressure |
| eng_rx_data | input | DW | Received word |
| ss_n | output | SLAVES | Active-low slave selects |
| irq_ready | output | 1 | Data-ready interrupt level |
| irq_ovf | output | 1 | Overflow interrupt level |

## Verification
The assertions assume that a bus master holds the strobe only until it sees the acknowledge. They also assume that the engine returns exactly one result strobe per accepted word and never strobes a result with no word in flight. The bench drives the bus through a task that drops the strobe on the acknowledge cycle. It models the engine as a loop that accepts one word, waits a fixed latency, and returns that word XOR 0x5A. The bench observes the overflow flags only through single status reads placed after fixed delays, so that polling cannot clear a flag before it is checked.

// File: rtl/spi_mr_pkg.sv
package spi_mr_pkg;
  localparam int ST_BUSY    = 0;
  localparam int ST_TXSPACE = 1;
  localparam int ST_RXDATA  = 2;
  localparam int ST_RXOVF   = 3;
  localparam int ST_TXOVF   = 4;
  localparam int ST_BITS    = 5;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/spi_mr_fifo.sv
module spi_mr_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 6,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty,
  output logic          one_left
);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign one_left = (cnt == CW'(1));
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // A refused push leaves the queue full when nothing leaves it
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/spi_mr_ss_decode.sv
module spi_mr_ss_decode #(
  parameter int SEL_W  = 1,
  parameter int SLAVES = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              active,
  output logic [SLAVES-1:0] ss_n
);
  for (genvar k = 0; k < SLAVES; k++) begin : g_line
    assign ss_n[k] = !(active && (sel == SEL_W'(k)));
  end
endmodule

// File: rtl/spi_mr_irq.sv
module spi_mr_irq #(
  parameter bit PER_WORD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_word,
  input  logic tx_idle,
  input  logic rx_drained,
  input  logic tx_wr_full,
  input  logic rx_in_full,
  input  logic stat_rd,
  output logic irq_ready,
  output logic irq_ovf,
  output logic tx_ovf,
  output logic rx_ovf
);
  logic dr_set;

  if (PER_WORD) begin : g_word
    assign dr_set = rx_word;
  end else begin : g_xact
    assign dr_set = rx_word && tx_idle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ready <= 1'b0;
      tx_ovf    <= 1'b0;
      rx_ovf    <= 1'b0;
    end else begin
      if (dr_set)          irq_ready <= 1'b1;
      else if (rx_drained) irq_ready <= 1'b0;
      if (tx_wr_full)      tx_ovf <= 1'b1;
      else if (stat_rd)    tx_ovf <= 1'b0;
      if (rx_in_full)      rx_ovf <= 1'b1;
      else if (stat_rd)    rx_ovf <= 1'b0;
    end
  end

  assign irq_ovf = tx_ovf | rx_ovf;

  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ovf) |-> $past(tx_wr_full || rx_in_full));

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !tx_wr_full && !rx_in_full) |=> !irq_ovf);

  assert_dr_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ready) |-> $past(rx_word));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_mr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 6,
  parameter int AW       = 3,
  parameter int SLAVES   = 2,
  parameter int SEL_W    = 1,
  parameter bit PER_WORD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_adr,
  input  logic [DW-1:0]     wb_wdat,
  output logic [DW-1:0]     wb_rdat,
  input  logic              wb_we,
  input  logic              wb_stb,
  output logic              wb_ack,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [DW-1:0]     eng_tx_data,
  input  logic              eng_rx_valid,
  input  logic [DW-1:0]     eng_rx_data,
  output logic [SLAVES-1:0] ss_n,
  output logic              irq_ready,
  output logic              irq_ovf
);
  logic          op, wr_data, rd_data, wr_ctrl, rd_stat;
  logic          tx_full, tx_empty, rx_full, rx_empty, rx_one;
  logic          tx_one_unused;
  logic          unused_wbits;
  logic          inflight, busy, tx_ovf, rx_ovf;
  logic [DW-1:0] rx_dout, status;
  logic [SEL_W-1:0] sel_q;

  assign op      = wb_stb && !wb_ack;
  assign wr_data = op &&  wb_we && (wb_adr == REG_DATA);
  assign rd_data = op && !wb_we && (wb_adr == REG_DATA);
  assign wr_ctrl = op &&  wb_we && (wb_adr == REG_CTRL);
  assign rd_stat = op && !wb_we && (wb_adr == REG_CTRL);
  assign unused_wbits = ^wb_wdat;

  spi_mr_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_txq (
    .clk(clk), .rst(rst), .push(wr_data), .din(wb_wdat),
    .pop(eng_tx_valid && eng_tx_ready), .dout(eng_tx_data),
    .full(tx_full), .empty(tx_empty), .one_left(tx_one_unused));

  spi_mr_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rxq (
    .clk(clk), .rst(rst), .push(eng_rx_valid), .din(eng_rx_data),
    .pop(rd_data), .dout(rx_dout),
    .full(rx_full), .empty(rx_empty), .one_left(rx_one));

  assign eng_tx_valid = !tx_empty && !inflight;
  assign busy         = !tx_empty || inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= 1'b0;
      sel_q    <= '0;
      wb_ack   <= 1'b0;
      wb_rdat  <= '0;
    end else begin
      if (eng_tx_valid && eng_tx_ready) inflight <= 1'b1;
      else if (eng_rx_valid)            inflight <= 1'b0;
      if (wr_ctrl) sel_q <= wb_wdat[SEL_W-1:0];
      wb_ack <= op;
      if (op && !wb_we)
        wb_rdat <= (wb_adr == REG_CTRL) ? status : (rx_empty ? '0 : rx_dout);
    end
  end

  always_comb begin
    status              = '0;
    status[ST_BUSY]     = busy;
    status[ST_TXSPACE]  = !tx_full;
    status[ST_RXDATA]   = !rx_empty;
    status[ST_RXOVF]    = rx_ovf;
    status[ST_TXOVF]    = tx_ovf;
  end

  spi_mr_ss_decode #(.SEL_W(SEL_W), .SLAVES(SLAVES)) u_ss (
    .sel(sel_q), .active(busy), .ss_n(ss_n));

  spi_mr_irq #(.PER_WORD(PER_WORD)) u_irq (
    .clk(clk), .rst(rst),
    .rx_word(eng_rx_valid), .tx_idle(tx_empty),
    .rx_drained(rd_data && rx_one && !eng_rx_valid),
    .tx_wr_full(wr_data && tx_full),
    .rx_in_full(eng_rx_valid && rx_full),
    .stat_rd(rd_stat),
    .irq_ready(irq_ready), .irq_ovf(irq_ovf),
    .tx_ovf(tx_ovf), .rx_ovf(rx_ovf));

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_valid && !eng_tx_ready) |=> (eng_tx_valid && $stable(eng_tx_data)));

  assert_one_word_R11: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_valid && eng_tx_ready) |=> !eng_tx_valid);

  assert_idle_release_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy) |-> (&ss_n));
endmodule

// File: tb/test_spi_master_regs.sv
module test_spi_master_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wb_adr = 1'b0, wb_we = 1'b0, wb_stb = 1'b0;
  logic [7:0] wb_wdat = '0;
  logic [7:0] wb_rdat, rdat_pw, tx_data, tx_data_pw;
  logic       wb_ack, ack_pw, tx_valid, tx_valid_pw;
  logic       eng_tx_ready = 1'b0, eng_rx_valid = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic [1:0] ss_n, ss_n_pw;
  logic       irq_ready, irq_ovf, irq_ready_pw, irq_ovf_pw;
  logic       hold = 1'b1;
  logic       done = 1'b0;
  int         checks = 0, fails = 0;
  logic [7:0] sb[$];

  always #5 clk = ~clk;

  spi_master_regs i_spi_master_regs (
    .clk(clk), .rst(rst), .wb_adr(wb_adr), .wb_wdat(wb_wdat), .wb_rdat(wb_rdat),
    .wb_we(wb_we), .wb_stb(wb_stb), .wb_ack(wb_ack),
    .eng_tx_valid(tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .ss_n(ss_n), .irq_ready(irq_ready), .irq_ovf(irq_ovf));

  spi_master_regs #(.PER_WORD(1'b1)) i_spi_master_regs_pw (
    .clk(clk), .rst(rst), .wb_adr(wb_adr), .wb_wdat(wb_wdat), .wb_rdat(rdat_pw),
    .wb_we(wb_we), .wb_stb(wb_stb), .wb_ack(ack_pw),
    .eng_tx_valid(tx_valid_pw), .eng_tx_ready(eng_tx_ready), .eng_tx_data(tx_data_pw),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .ss_n(ss_n_pw), .irq_ready(irq_ready_pw), .irq_ovf(irq_ovf_pw));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic adr, input logic we, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    wb_adr = adr; wb_we = we; wb_wdat = d; wb_stb = 1'b1;
    @(negedge clk);
    chk("R1 ack high", {7'd0, wb_ack}, 8'd1);
    q = wb_rdat;
    wb_stb = 1'b0;
    @(negedge clk);
    chk("R1 ack single", {7'd0, wb_ack}, 8'd0);
  endtask

  task automatic wr(input logic adr, input logic [7:0] d);
    logic [7:0] q;
    bus(adr, 1'b1, d, q);
  endtask

  task automatic rd(input logic adr, output logic [7:0] q);
    bus(adr, 1'b0, 8'h00, q);
  endtask

  task automatic send(input logic [7:0] d);
    sb.push_back(d ^ 8'h5A);
    wr(1'b0, d);
  endtask

  task automatic take();
    logic [7:0] q, e;
    rd(1'b0, q);
    e = (sb.size() > 0) ? sb.pop_front() : 8'h00;
    chk("R2 rx order", q, e);
  endtask

  // Engine model: one word at a time, fixed latency, returns word ^ 0x5A
  initial begin
    logic [7:0] d;
    forever begin
      @(negedge clk);
      if (tx_valid && !hold) begin
        d = tx_data;
        eng_tx_ready = 1'b1;
        @(negedge clk);
        eng_tx_ready = 1'b0;
        repeat (6) @(negedge clk);
        eng_rx_data = d ^ 8'h5A;
        eng_rx_valid = 1'b1;
        @(negedge clk);
        eng_rx_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset ack", {7'd0, wb_ack}, 8'd0);
    chk("reset R3 ss", {6'd0, ss_n}, 8'h03);
    chk("reset R8 irq", {6'd0, irq_ready, irq_ovf}, 8'h00);
    chk("reset R11 valid", {7'd0, tx_valid}, 8'd0);
    rd(1'b1, q);
    chk("R4 idle status", q, 8'h02);

    // Transaction of two words on slave 1
    wr(1'b1, 8'h01);
    send(8'h11);
    send(8'h22);
    chk("R11 valid offered", {7'd0, tx_valid}, 8'd1);
    chk("R3 slave1 low", {6'd0, ss_n}, 8'h01);
    rd(1'b1, q);
    chk("R4 busy status", q, 8'h03);
    hold = 1'b0;
    for (int i = 0; i < 50; i++) begin
      rd(1'b1, q);
      if (q[2]) break;
    end
    chk("R9 per-word irq", {7'd0, irq_ready_pw}, 8'd1);
    chk("R8 no irq mid-transaction", {7'd0, irq_ready}, 8'd0);
    repeat (20) @(negedge clk);
    chk("R8 irq at end", {7'd0, irq_ready}, 8'd1);
    chk("R3 released", {6'd0, ss_n}, 8'h03);
    take();
    take();
    chk("R10 irq cleared", {6'd0, irq_ready, irq_ready_pw}, 8'h00);

    // Transmit overflow on slave 0
    hold = 1'b1;
    wr(1'b1, 8'h00);
    for (int i = 0; i < 6; i++) send(8'h30 + 8'(i));
    rd(1'b1, q);
    chk("R4 tx full status", q, 8'h01);
    chk("R3 slave0 low", {6'd0, ss_n}, 8'h02);
    wr(1'b0, 8'hEE);
    chk("R5 ovf irq", {7'd0, irq_ovf}, 8'd1);
    rd(1'b1, q);
    chk("R5 tx ovf bit", q, 8'h11);
    chk("R7 irq cleared", {7'd0, irq_ovf}, 8'd0);
    rd(1'b1, q);
    chk("R7 bits cleared", q, 8'h01);
    hold = 1'b0;
    repeat (80) @(negedge clk);
    rd(1'b1, q);
    chk("R4 rx full status", q, 8'h06);

    // Receive overflow: word returns into a full receive FIFO
    wr(1'b0, 8'h77);
    repeat (20) @(negedge clk);
    chk("R6 ovf irq", {7'd0, irq_ovf}, 8'd1);
    rd(1'b1, q);
    chk("R6 rx ovf bit", q, 8'h0E);
    for (int i = 0; i < 6; i++) take();
    rd(1'b0, q);
    chk("R2 empty read zero", q, 8'h00);
    chk("R10 irq cleared", {7'd0, irq_ready}, 8'd0);
    rd(1'b1, q);
    chk("R4 final status", q, 8'h02);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule